// File: doc/BRIEF.md
# Data-Valid Framed Serial Parity Detector

This block computes the parity of a serial bit stream. Data bits arrive one per clock on `ser_bit`, and a framing strobe, `frame_vld`, marks how long each vector lasts. A vector starts on the first cycle the strobe is sampled high after being low. It ends on the first cycle the strobe is sampled low again, so the strobe alone sets the vector length. The output `par_odd` is 1 when the vector held an odd number of ones and 0 when it held an even number. After the strobe drops, the output keeps the final result until the first bit of the next vector arrives.

The block is a four-state Moore machine. Two of its states are idle (even, odd) and two are running (even, odd). The output is decoded from the registered state only. The reset is asynchronous and active low, and it is released on a clock edge through a short synchronizer. It is meant for power-up only: each vector start discards the old result, so no reset is needed between vectors. A parameter selects how the state is stored: binary, Gray or one-hot. In the one-hot form, any illegal code reads as idle-even, and the next vector start writes a legal code.

Top module: `dvpar_top`

## Requirements
- R1: While `rst_n` is low, and after its release until the first vector starts, `par_odd` is 0.
- R2: The first sample of a vector (strobe high, previous sample low) sets `par_odd` to that sample of `ser_bit`, discarding any earlier result.
- R3: Each later sample taken with the strobe still high inverts `par_odd` when `ser_bit` is 1 and leaves it unchanged when `ser_bit` is 0.
- R4: While the strobe is sampled low, `par_odd` keeps its value and `ser_bit` has no effect on it.
- R5: A strobe that is high for a single cycle forms a 1-bit vector. A single low cycle between two high stretches is enough to separate two vectors.
- R6: Inputs are taken on the rising clock edge, and `par_odd` shows the effect of that sample after the same edge. As an example, the vector 1,0,1,1,0 ends at 1 and the vector 1,1,0,1,1 ends at 0.
- R7: The binary, Gray and one-hot state encodings behave identically at the ports. In the one-hot encoding, after any cycle with the strobe high, the state register holds a legal code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; inputs are sampled on the rising edge |
| rst_n | input | 1 | Power-up reset, asynchronous assert, active low |
| frame_vld | input | 1 | High for every cycle that carries a bit of the current vector |
| ser_bit | input | 1 | Serial data bit |
| par_odd | output | 1 | Parity of the current or last vector (1 = odd count of ones) |

## Verification
Every result is due one rising edge after the sample that causes it. The bench changes the inputs on the falling edge, and at the next falling edge it advances its reference model by the sample taken at the rising edge in between. It compares that model against both a Gray-encoded instance and a one-hot instance, and only then applies the next inputs. No output is read at the rising edge. After the reset is released, the strobe stays low for at least the depth of the synchronizer, so the first vector never meets a reset that is still held inside the block.

// File: rtl/dvpar_pkg.sv
package dvpar_pkg;

  // Abstract machine state, independent of the stored encoding
  typedef enum logic [1:0] {
    PS_IDLE_EVEN,
    PS_IDLE_ODD,
    PS_RUN_EVEN,
    PS_RUN_ODD
  } pstate_e;

  // Encoding choices for the state register
  typedef enum logic [1:0] {
    ENC_BINARY,
    ENC_GRAY,
    ENC_ONEHOT
  } enc_e;

  function automatic int unsigned code_width(enc_e e);
    return (e == ENC_ONEHOT) ? 4 : 2;
  endfunction

  // Code of the power-up state in a 4-bit container
  function automatic logic [3:0] idle_even_code(enc_e e);
    return (e == ENC_ONEHOT) ? 4'b0001 : 4'b0000;
  endfunction

  function automatic pstate_e ps_make(logic run, logic odd);
    pstate_e s;
    case ({run, odd})
      2'b00:   s = PS_IDLE_EVEN;
      2'b01:   s = PS_IDLE_ODD;
      2'b10:   s = PS_RUN_EVEN;
      default: s = PS_RUN_ODD;
    endcase
    return s;
  endfunction

  function automatic logic ps_is_run(pstate_e s);
    return (s == PS_RUN_EVEN) || (s == PS_RUN_ODD);
  endfunction

  function automatic logic ps_is_odd(pstate_e s);
    return (s == PS_IDLE_ODD) || (s == PS_RUN_ODD);
  endfunction

endpackage

// File: rtl/dvpar_rst_sync.sv
module dvpar_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/dvpar_next.sv
module dvpar_next
  import dvpar_pkg::*;
(
  input  pstate_e cur_st,
  input  logic    vld,
  input  logic    dbit,
  output pstate_e nxt_st,
  output logic    upd_en
);

  logic cur_run;
  logic cur_odd;

  always_comb begin
    cur_run = ps_is_run(cur_st);
    cur_odd = ps_is_odd(cur_st);
    // Clock enable: idle with no strobe leaves the register untouched
    upd_en  = vld | cur_run;
    if (!vld) begin
      nxt_st = ps_make(1'b0, cur_odd);
    end else if (!cur_run) begin
      nxt_st = ps_make(1'b1, dbit);
    end else begin
      nxt_st = ps_make(1'b1, cur_odd ^ dbit);
    end
  end

endmodule

// File: rtl/dvpar_codec.sv
module dvpar_codec
  import dvpar_pkg::*;
#(
  parameter enc_e        ENC = ENC_GRAY,
  parameter int unsigned CW  = code_width(ENC)
) (
  input  pstate_e       st_in,
  output logic [CW-1:0] code_out,
  input  logic [CW-1:0] code_in,
  output pstate_e       st_out,
  output logic          legal
);

  generate
    if (ENC == ENC_ONEHOT) begin : g_onehot
      always_comb begin
        case (st_in)
          PS_IDLE_EVEN: code_out = 4'b0001;
          PS_IDLE_ODD:  code_out = 4'b0010;
          PS_RUN_EVEN:  code_out = 4'b0100;
          default:      code_out = 4'b1000;
        endcase
      end
      always_comb begin
        legal = 1'b1;
        case (code_in)
          4'b0001: st_out = PS_IDLE_EVEN;
          4'b0010: st_out = PS_IDLE_ODD;
          4'b0100: st_out = PS_RUN_EVEN;
          4'b1000: st_out = PS_RUN_ODD;
          default: begin
            st_out = PS_IDLE_EVEN;
            legal  = 1'b0;
          end
        endcase
      end
    end else if (ENC == ENC_GRAY) begin : g_gray
      // Ring order idle_even -> run_even -> run_odd -> idle_odd
      always_comb begin
        case (st_in)
          PS_IDLE_EVEN: code_out = 2'b00;
          PS_RUN_EVEN:  code_out = 2'b01;
          PS_RUN_ODD:   code_out = 2'b11;
          default:      code_out = 2'b10;
        endcase
      end
      always_comb begin
        legal = 1'b1;
        case (code_in)
          2'b00:   st_out = PS_IDLE_EVEN;
          2'b01:   st_out = PS_RUN_EVEN;
          2'b11:   st_out = PS_RUN_ODD;
          default: st_out = PS_IDLE_ODD;
        endcase
      end
    end else begin : g_binary
      always_comb begin
        code_out = st_in;
        legal    = 1'b1;
        st_out   = pstate_e'(code_in);
      end
    end
  endgenerate

endmodule

// File: rtl/dvpar_state_reg.sv
module dvpar_state_reg #(
  parameter int unsigned     CW       = 2,
  parameter logic [CW-1:0]   RST_CODE = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] d,
  output logic [CW-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= RST_CODE;
    end else if (en) begin
      q <= d;
    end
  end

endmodule

// File: rtl/dvpar_top.sv
module dvpar_top
  import dvpar_pkg::*;
#(
  parameter enc_e        ENC         = ENC_GRAY,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_vld,
  input  logic ser_bit,
  output logic par_odd
);

  localparam int unsigned   CW       = code_width(ENC);
  localparam logic [3:0]    RST_FULL = idle_even_code(ENC);
  localparam logic [CW-1:0] RST_CODE = RST_FULL[CW-1:0];

  logic          rst_sync_n;
  logic [CW-1:0] code_q;
  logic [CW-1:0] code_d;
  pstate_e       cur_st;
  pstate_e       nxt_st;
  logic          upd_en;
  logic          code_legal;
  logic          running;

  dvpar_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_n_sync (rst_sync_n)
  );

  dvpar_codec #(.ENC(ENC), .CW(CW)) u_codec (
    .st_in    (nxt_st),
    .code_out (code_d),
    .code_in  (code_q),
    .st_out   (cur_st),
    .legal    (code_legal)
  );

  dvpar_next u_next (
    .cur_st (cur_st),
    .vld    (frame_vld),
    .dbit   (ser_bit),
    .nxt_st (nxt_st),
    .upd_en (upd_en)
  );

  dvpar_state_reg #(.CW(CW), .RST_CODE(RST_CODE)) u_reg (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (upd_en),
    .d     (code_d),
    .q     (code_q)
  );

  // Moore outputs: decoded from the registered state only
  assign par_odd = ps_is_odd(cur_st);
  assign running = ps_is_run(cur_st);

endmodule

// File: rtl/dvpar_chk.sv
module dvpar_chk (
  input logic clk,
  input logic rst_ok,
  input logic frame_vld,
  input logic ser_bit,
  input logic par_odd,
  input logic running,
  input logic code_legal
);

  // R1
  always @(negedge clk) begin
    if (!rst_ok) begin
      reset_even_chk: assert (par_odd == 1'b0 && running == 1'b0);
    end
  end

  // R2
  start_fresh_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (!running && frame_vld) |=> (par_odd == $past(ser_bit)));

  // R3
  fold_bit_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (running && frame_vld) |=> (par_odd == ($past(par_odd) ^ $past(ser_bit))));

  // R4
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !frame_vld |=> ($stable(par_odd) && !running));

  // R5
  enter_run_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    frame_vld |=> running);

  // R7
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    frame_vld |=> code_legal);

endmodule

bind dvpar_top dvpar_chk u_chk (
  .clk        (clk),
  .rst_ok     (rst_sync_n),
  .frame_vld  (frame_vld),
  .ser_bit    (ser_bit),
  .par_odd    (par_odd),
  .running    (running),
  .code_legal (code_legal)
);

// File: tb/sim_dvpar_top.sv
`timescale 1ns/1ps
module sim_dvpar_top;
  import dvpar_pkg::*;

  logic clk;
  logic rst_n;
  logic frame_vld;
  logic ser_bit;
  logic par_gray;
  logic par_oh;

  int n_cmp;
  int n_bad;
  bit done;

  // Reference model state
  int m_par;
  bit m_run;
  bit cur_v;
  bit cur_b;

  dvpar_top #(.ENC(ENC_GRAY)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .ser_bit(ser_bit), .par_odd(par_gray)
  );

  dvpar_top #(.ENC(ENC_ONEHOT)) u1 (
    .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .ser_bit(ser_bit), .par_odd(par_oh)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic compare(input string tag, input int exp_v);
    n_cmp++;
    if (int'(par_gray) != exp_v) begin
      n_bad++;
      $display("FAIL %s gray: actual=%0d expected=%0d at %0t", tag, par_gray, exp_v, $time);
    end
    n_cmp++;
    if (int'(par_oh) != exp_v) begin
      n_bad++;
      $display("FAIL %s R7 onehot: actual=%0d expected=%0d at %0t", tag, par_oh, exp_v, $time);
    end
  endtask

  // One cycle: advance model by the sample taken at the rising edge just passed,
  // compare, then drive the next inputs.
  task automatic step(input bit v, input bit b, input string tag);
    @(negedge clk);
    if (cur_v) begin
      if (!m_run) m_par = int'(cur_b);
      else        m_par = m_par ^ int'(cur_b);
      m_run = 1'b1;
    end else begin
      m_run = 1'b0;
    end
    compare(tag, m_par);
    frame_vld = v;
    ser_bit   = b;
    cur_v     = v;
    cur_b     = b;
  endtask

  task automatic send_vec(input logic [63:0] bits, input int len, input string tag);
    for (int i = len - 1; i >= 0; i--) step(1'b1, bits[i], tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, i[0], tag);
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; done = 1'b0;
    m_par = 0; m_run = 1'b0; cur_v = 1'b0; cur_b = 1'b0;
    rst_n = 1'b0; frame_vld = 1'b0; ser_bit = 1'b0;

    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, "R1");

    // Two 5-bit vectors
    send_vec(64'b10110, 5, "R3");
    idle(5, "R4");
    compare("R6", 1);
    send_vec(64'b11011, 5, "R3");
    idle(4, "R4");
    compare("R6", 0);

    // Fresh start after an odd result
    send_vec(64'b111, 3, "R3");
    idle(1, "R4");
    send_vec(64'b0, 1, "R2");
    send_vec(64'b00, 2, "R3");
    idle(2, "R2");
    compare("R2", 0);
    send_vec(64'b1, 1, "R2");
    idle(1, "R5");
    send_vec(64'b1, 1, "R5");
    idle(2, "R5");
    compare("R5", 1);
    send_vec(64'b0, 1, "R5");
    idle(3, "R5");
    compare("R5", 0);

    // Long vector
    for (int i = 0; i < 40; i++) step(1'b1, (i % 3) == 0, "R3");
    idle(3, "R4");
    compare("R4", 0);
    for (int i = 0; i < 20; i++) step(1'b1, (i % 4) != 1, "R3");
    idle(6, "R4");
    compare("R6", 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R1..: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule